// File: doc/BRIEF.md
# Linked-List Hardware Queue Manager

This block keeps a group of packet queues whose entries are descriptors. It does not give each queue its own FIFO buffer. Every queue is a singly linked chain of link indices, and all queues share one linking RAM. The RAM holds, for each descriptor, the index of the descriptor that follows it. Each queue keeps three registers: a head index, a tail index and an entry count. A descriptor needs exactly one link word, whichever queue it sits in, so storage grows with the number of descriptors and not with queue depth multiplied by queue count.

To enqueue, a bus master writes a descriptor address to the push port together with a queue number. A table of descriptor regions, fixed by parameters, turns that address into a link index. Each region has a base address, a descriptor size that is a power of two, a descriptor count and the link index of its first descriptor. To dequeue, a master issues a read on the separate pop port. One cycle later the block returns the head descriptor's address, rebuilt from its link index through the same region table. Any queue's entry count can be read at any time. The manager owns a contiguous range of queue numbers, set by a base and a count.

Top module: `llq_manager`

## Requirements
- R1: A push whose queue number is in range and whose address falls inside a region appends that descriptor at the tail of the queue and raises the queue's count by one on the next clock edge. A push to an empty queue makes the new descriptor both head and tail.
- R2: A pop to a non-empty queue returns the head descriptor's address on `popRdata`, with `popRvalid` high, in the cycle after `popValid`. Successive pops return descriptors in the order they were pushed, and each pop lowers the count by one.
- R3: Translation rules. The link index is region start + ((address − region base) >> log2 size). Low offset bits are therefore discarded, and a pop returns base + ((index − start) << log2 size). The lowest-numbered matching region wins. Defaults: region 0 has base 0x1000_0000, 64-byte descriptors, 16 descriptors and start index 0; region 1 has base 0x2000_0000, 128-byte descriptors, 16 descriptors and start index 16.
- R4: A push whose address lies in no region is ignored. The count does not change and later pops do not see it.
- R5: A pop from an empty queue returns 0 with `popRvalid` high. The count stays 0.
- R6: Queue numbers outside [QUEUE_BASE, QUEUE_BASE+NUM_QUEUES) are ignored. The default range is 16..23. A push there changes nothing, a pop returns 0, and a count read returns 0.
- R7: `cntValue` shows, without a clock delay, the current entry count of the queue selected by `cntQueue`.
- R8: When a push and a pop address the same queue in the same cycle, the pop is served first and the push is applied after it. On an empty queue the pop returns 0 and the pushed descriptor becomes the only entry. On a queue with one entry the pop returns the old head and the new descriptor becomes the only entry. In both cases the count changes by at most one per cycle.
- R9: Queues that share the linking RAM stay independent. Interleaved pushes to different queues keep each queue's own order.
- R10: After reset every queue is empty, every count reads 0 and `popRvalid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pushValid | input | 1 | Push request strobe |
| pushQueue | input | QNUM_W | Queue number for the push |
| pushAddr | input | ADDR_W | Descriptor address to enqueue |
| popValid | input | 1 | Pop request strobe |
| popQueue | input | QNUM_W | Queue number for the pop |
| popRvalid | output | 1 | Pop response valid, one cycle after popValid |
| popRdata | output | ADDR_W | Popped descriptor address, or 0 |
| cntQueue | input | QNUM_W | Queue number whose count is shown |
| cntValue | output | CNT_W | Entry count of cntQueue |

## Verification
A push and a pop can reach the same queue in the same cycle, and the head, tail, count and link-write decisions must then follow the pop-then-push order. The stimulus aims a quarter of the random pops at the queue being pushed in that cycle. Directed steps cover the collision on an empty queue, on a one-entry queue and on a longer queue. Each returned address and each count is compared with a bench model that applies the pop before the push.

// File: rtl/lqm_pkg.sv
package lqm_pkg;

  // Strobes passed from the control path to the link datapath each cycle
  typedef struct packed {
    logic popEn;   // a pop request was presented (response due next cycle)
    logic popHit;  // the pop targets a non-empty queue in range
    logic linkWe;  // write a next-link word into the linking RAM
  } lqmStrobe_t;

endpackage

// File: rtl/lqm_region_xlate.sv
module lqm_region_xlate #(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 5,
  parameter int NUM_REGIONS = 2,
  parameter logic [NUM_REGIONS*ADDR_W-1:0] REGION_BASE  = {32'h2000_0000, 32'h1000_0000},
  parameter logic [NUM_REGIONS*5-1:0]      REGION_LG    = {5'd7, 5'd6},
  parameter logic [NUM_REGIONS*16-1:0]     REGION_COUNT = {16'd16, 16'd16},
  parameter logic [NUM_REGIONS*16-1:0]     REGION_START = {16'd16, 16'd0}
) (
  input  logic [ADDR_W-1:0] pushAddr,
  output logic              pushHit,
  output logic [IDX_W-1:0]  pushIdx,
  input  logic [IDX_W-1:0]  popIdx,
  output logic [ADDR_W-1:0] popAddr
);

  logic [NUM_REGIONS-1:0] fwdHit;
  logic [NUM_REGIONS-1:0] invHit;
  logic [IDX_W-1:0]       fwdIdx  [NUM_REGIONS];
  logic [ADDR_W-1:0]      invAddr [NUM_REGIONS];

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : gRegion
    localparam logic [ADDR_W-1:0] RBase  = REGION_BASE[r*ADDR_W +: ADDR_W];
    localparam int unsigned       RLg    = REGION_LG[r*5 +: 5];
    localparam logic [31:0]       RCount = 32'(REGION_COUNT[r*16 +: 16]);
    localparam logic [31:0]       RStart = 32'(REGION_START[r*16 +: 16]);

    logic [ADDR_W-1:0] slot;
    assign slot = (pushAddr - RBase) >> RLg;

    // address -> link index
    assign fwdHit[r] = (pushAddr >= RBase) && (32'(slot) < RCount);
    assign fwdIdx[r] = IDX_W'(32'(slot) + RStart);

    // link index -> descriptor address
    assign invHit[r]  = (32'(popIdx) >= RStart) && (32'(popIdx) < RStart + RCount);
    assign invAddr[r] = RBase + (ADDR_W'(32'(popIdx) - RStart) << RLg);
  end

  // lowest-numbered region has priority
  always_comb begin
    pushHit = 1'b0;
    pushIdx = '0;
    popAddr = '0;
    for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
      if (fwdHit[r]) begin
        pushHit = 1'b1;
        pushIdx = fwdIdx[r];
      end
      if (invHit[r]) popAddr = invAddr[r];
    end
  end

endmodule

// File: rtl/lqm_datapath.sv
module lqm_datapath
  import lqm_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 5,
  parameter int NUM_DESC    = 32,
  parameter int NUM_REGIONS = 2,
  parameter logic [NUM_REGIONS*ADDR_W-1:0] REGION_BASE  = {32'h2000_0000, 32'h1000_0000},
  parameter logic [NUM_REGIONS*5-1:0]      REGION_LG    = {5'd7, 5'd6},
  parameter logic [NUM_REGIONS*16-1:0]     REGION_COUNT = {16'd16, 16'd16},
  parameter logic [NUM_REGIONS*16-1:0]     REGION_START = {16'd16, 16'd0}
) (
  input  logic              clk,
  input  logic              rstN,
  input  lqmStrobe_t        strobes,
  input  logic [IDX_W-1:0]  popIdx,
  input  logic [IDX_W-1:0]  linkWaddr,
  input  logic [IDX_W-1:0]  linkWdata,
  input  logic [ADDR_W-1:0] pushAddr,
  output logic              pushHit,
  output logic [IDX_W-1:0]  pushIdx,
  output logic [IDX_W-1:0]  linkRdata,
  output logic              popRvalid,
  output logic [ADDR_W-1:0] popRdata
);

  logic [IDX_W-1:0]  linkRam [NUM_DESC];
  logic [ADDR_W-1:0] popAddr;

  lqm_region_xlate #(
    .ADDR_W      (ADDR_W),
    .IDX_W       (IDX_W),
    .NUM_REGIONS (NUM_REGIONS),
    .REGION_BASE (REGION_BASE),
    .REGION_LG   (REGION_LG),
    .REGION_COUNT(REGION_COUNT),
    .REGION_START(REGION_START)
  ) uXlate (
    .pushAddr(pushAddr),
    .pushHit (pushHit),
    .pushIdx (pushIdx),
    .popIdx  (popIdx),
    .popAddr (popAddr)
  );

  // successor of the head being popped
  assign linkRdata = linkRam[popIdx];

  always_ff @(posedge clk) begin
    if (strobes.linkWe) linkRam[linkWaddr] <= linkWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      popRvalid <= 1'b0;
      popRdata  <= '0;
    end else begin
      popRvalid <= strobes.popEn;
      popRdata  <= strobes.popHit ? popAddr : '0;
    end
  end

endmodule

// File: rtl/lqm_ctrl.sv
module lqm_ctrl
  import lqm_pkg::*;
#(
  parameter int NUM_QUEUES = 8,
  parameter int QUEUE_BASE = 16,
  parameter int QNUM_W     = 8,
  parameter int IDX_W      = 5,
  parameter int CNT_W      = 6,
  localparam int QIDX_W    = $clog2(NUM_QUEUES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [QNUM_W-1:0] pushQueue,
  input  logic              pushHit,
  input  logic [IDX_W-1:0]  pushIdx,
  input  logic              popValid,
  input  logic [QNUM_W-1:0] popQueue,
  input  logic [IDX_W-1:0]  linkRdata,
  input  logic [QNUM_W-1:0] cntQueue,
  output lqmStrobe_t        strobes,
  output logic [IDX_W-1:0]  popIdx,
  output logic [IDX_W-1:0]  linkWaddr,
  output logic [IDX_W-1:0]  linkWdata,
  output logic [CNT_W-1:0]  cntValue
);

  localparam logic [QNUM_W:0] QLo = (QNUM_W+1)'(QUEUE_BASE);
  localparam logic [QNUM_W:0] QHi = (QNUM_W+1)'(QUEUE_BASE + NUM_QUEUES);

  logic [IDX_W-1:0]  head  [NUM_QUEUES];
  logic [IDX_W-1:0]  tail  [NUM_QUEUES];
  logic [CNT_W-1:0]  count [NUM_QUEUES];

  logic              pushIn, popIn, cntIn;
  logic [QIDX_W-1:0] pushQ, popQ, cntQ;
  logic              popOk, pushOk, sameQ;
  logic [CNT_W-1:0]  pushCntAfter;

  assign pushIn = ({1'b0, pushQueue} >= QLo) && ({1'b0, pushQueue} < QHi);
  assign popIn  = ({1'b0, popQueue}  >= QLo) && ({1'b0, popQueue}  < QHi);
  assign cntIn  = ({1'b0, cntQueue}  >= QLo) && ({1'b0, cntQueue}  < QHi);
  assign pushQ  = QIDX_W'(pushQueue - QNUM_W'(QUEUE_BASE));
  assign popQ   = QIDX_W'(popQueue  - QNUM_W'(QUEUE_BASE));
  assign cntQ   = QIDX_W'(cntQueue  - QNUM_W'(QUEUE_BASE));

  always_comb begin
    popOk        = popValid && popIn && (count[popQ] != '0);
    pushOk       = pushValid && pushIn && pushHit;
    sameQ        = popOk && (popQ == pushQ);
    // pop is applied before the push on a shared queue
    pushCntAfter = count[pushQ] - CNT_W'(sameQ);
    strobes.popEn  = popValid;
    strobes.popHit = popOk;
    strobes.linkWe = pushOk && (pushCntAfter != '0);
    linkWaddr      = tail[pushQ];
    linkWdata      = pushIdx;
    popIdx         = head[popQ];
    cntValue       = cntIn ? count[cntQ] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int q = 0; q < NUM_QUEUES; q++) begin
        head[q]  <= '0;
        tail[q]  <= '0;
        count[q] <= '0;
      end
    end else begin
      for (int q = 0; q < NUM_QUEUES; q++) begin
        if (popOk && popQ == QIDX_W'(q)) begin
          head[q]  <= linkRdata;
          count[q] <= count[q] - CNT_W'(1);
        end
        if (pushOk && pushQ == QIDX_W'(q)) begin
          if (pushCntAfter == '0) head[q] <= pushIdx;
          tail[q]  <= pushIdx;
          count[q] <= pushCntAfter + CNT_W'(1);
        end
      end
    end
  end

  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (popValid && popIn && count[popQ] == '0 && !(pushOk && pushQ == popQ))
      |=> count[$past(popQ)] == '0); // R5

  AST_PUSH_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (pushOk && !sameQ) |=> count[$past(pushQ)] == $past(count[pushQ]) + CNT_W'(1)); // R1

  for (genvar g = 0; g < NUM_QUEUES; g++) begin : gStep
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (count[g] == $past(count[g])) ||
               (count[g] == $past(count[g]) + CNT_W'(1)) ||
               (count[g] + CNT_W'(1) == $past(count[g]))); // R8
  end

endmodule

// File: rtl/llq_manager.sv
module llq_manager
  import lqm_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_QUEUES  = 8,
  parameter int QUEUE_BASE  = 16,
  parameter int QNUM_W      = 8,
  parameter int NUM_DESC    = 32,
  parameter int NUM_REGIONS = 2,
  parameter logic [NUM_REGIONS*ADDR_W-1:0] REGION_BASE  = {32'h2000_0000, 32'h1000_0000},
  parameter logic [NUM_REGIONS*5-1:0]      REGION_LG    = {5'd7, 5'd6},
  parameter logic [NUM_REGIONS*16-1:0]     REGION_COUNT = {16'd16, 16'd16},
  parameter logic [NUM_REGIONS*16-1:0]     REGION_START = {16'd16, 16'd0},
  localparam int IDX_W = $clog2(NUM_DESC),
  localparam int CNT_W = $clog2(NUM_DESC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [QNUM_W-1:0] pushQueue,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic              popValid,
  input  logic [QNUM_W-1:0] popQueue,
  output logic              popRvalid,
  output logic [ADDR_W-1:0] popRdata,
  input  logic [QNUM_W-1:0] cntQueue,
  output logic [CNT_W-1:0]  cntValue
);

  lqmStrobe_t       strobes;
  logic [IDX_W-1:0] popIdx, linkWaddr, linkWdata, linkRdata, pushIdx;
  logic             pushHit;

  lqm_ctrl #(
    .NUM_QUEUES(NUM_QUEUES),
    .QUEUE_BASE(QUEUE_BASE),
    .QNUM_W    (QNUM_W),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .pushValid(pushValid),
    .pushQueue(pushQueue),
    .pushHit  (pushHit),
    .pushIdx  (pushIdx),
    .popValid (popValid),
    .popQueue (popQueue),
    .linkRdata(linkRdata),
    .cntQueue (cntQueue),
    .strobes  (strobes),
    .popIdx   (popIdx),
    .linkWaddr(linkWaddr),
    .linkWdata(linkWdata),
    .cntValue (cntValue)
  );

  lqm_datapath #(
    .ADDR_W      (ADDR_W),
    .IDX_W       (IDX_W),
    .NUM_DESC    (NUM_DESC),
    .NUM_REGIONS (NUM_REGIONS),
    .REGION_BASE (REGION_BASE),
    .REGION_LG   (REGION_LG),
    .REGION_COUNT(REGION_COUNT),
    .REGION_START(REGION_START)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .popIdx   (popIdx),
    .linkWaddr(linkWaddr),
    .linkWdata(linkWdata),
    .pushAddr (pushAddr),
    .pushHit  (pushHit),
    .pushIdx  (pushIdx),
    .linkRdata(linkRdata),
    .popRvalid(popRvalid),
    .popRdata (popRdata)
  );

  localparam logic [QNUM_W:0] QLo = (QNUM_W+1)'(QUEUE_BASE);
  localparam logic [QNUM_W:0] QHi = (QNUM_W+1)'(QUEUE_BASE + NUM_QUEUES);

  AST_POP_RESP: assert property (@(posedge clk) disable iff (!rstN)
    popValid |=> popRvalid); // R2

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (popValid && cntQueue == popQueue && cntValue == '0) |=> popRdata == '0); // R5

  AST_RANGE_POP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (popValid && !(({1'b0, popQueue} >= QLo) && ({1'b0, popQueue} < QHi)))
      |=> popRdata == '0); // R6

endmodule

// File: tb/sim_llq_manager.sv
module sim_llq_manager;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pushValid = 1'b0;
  logic [7:0]  pushQueue = '0;
  logic [31:0] pushAddr = '0;
  logic        popValid = 1'b0;
  logic [7:0]  popQueue = '0;
  logic        popRvalid;
  logic [31:0] popRdata;
  logic [7:0]  cntQueue = '0;
  logic [5:0]  cntValue;

  int nChecks = 0;
  int nFail   = 0;

  logic [31:0] mq [8][$];
  bit          used [32];

  always #2 clk = ~clk;

  llq_manager u0 (
    .clk(clk), .rstN(rstN),
    .pushValid(pushValid), .pushQueue(pushQueue), .pushAddr(pushAddr),
    .popValid(popValid), .popQueue(popQueue),
    .popRvalid(popRvalid), .popRdata(popRdata),
    .cntQueue(cntQueue), .cntValue(cntValue)
  );

  // ---------------- reference functions (from R3, R6) ----------------
  function automatic bit xlate(input logic [31:0] a, output int idx);
    logic [31:0] rb [2] = '{32'h1000_0000, 32'h2000_0000};
    int          rl [2] = '{6, 7};
    int          rc [2] = '{16, 16};
    int          rs [2] = '{0, 16};
    idx = 0;
    for (int r = 0; r < 2; r++)
      if (a >= rb[r] && ((a - rb[r]) >> rl[r]) < 32'(rc[r])) begin
        idx = rs[r] + int'((a - rb[r]) >> rl[r]);
        return 1'b1;
      end
    return 1'b0;
  endfunction

  function automatic logic [31:0] idxToAddr(input int idx);
    if (idx < 16) return 32'h1000_0000 + 32'(idx << 6);
    return 32'h2000_0000 + 32'((idx - 16) << 7);
  endfunction

  function automatic bit qIn(input logic [7:0] q);
    return q >= 8'd16 && q < 8'd24;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkCnt(input logic [7:0] q, input string tag);
    int exp;
    cntQueue = q;
    #1;
    exp = qIn(q) ? mq[q - 8'd16].size() : 0;
    chk(cntValue == 6'(exp), tag, 32'(cntValue), 32'(exp));
  endtask

  // one bus cycle: model applies pop first, then push (R8)
  task automatic step(input bit pv, input logic [7:0] pq, input logic [31:0] pa,
                      input bit ov, input logic [7:0] oq, input string tag);
    logic [31:0] expPop;
    int idx;
    expPop = '0;
    if (ov && qIn(oq) && mq[oq - 8'd16].size() > 0) begin
      expPop = mq[oq - 8'd16].pop_front();
      if (xlate(expPop, idx)) used[idx] = 1'b0;
    end
    if (pv && qIn(pq) && xlate(pa, idx)) begin
      mq[pq - 8'd16].push_back(idxToAddr(idx));
      used[idx] = 1'b1;
    end
    pushValid = pv; pushQueue = pq; pushAddr = pa;
    popValid  = ov; popQueue  = oq;
    @(posedge clk);
    @(negedge clk);
    pushValid = 1'b0;
    popValid  = 1'b0;
    if (ov) chk(popRvalid === 1'b1 && popRdata === expPop, tag, popRdata, expPop);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 32; i++) used[i] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10: reset state
    chk(popRvalid == 1'b0, "R10 popRvalid", 32'(popRvalid), 32'd0);
    for (int q = 16; q < 24; q++) chkCnt(8'(q), "R10 count");

    // R5: empty pop
    step(0, 8'd0, 32'd0, 1, 8'd16, "R5 empty pop");
    chkCnt(8'd16, "R5 count");

    // R1: three pushes
    step(1, 8'd16, 32'h1000_0000, 0, 8'd0, "R1");
    step(1, 8'd16, 32'h1000_0040, 0, 8'd0, "R1");
    step(1, 8'd16, 32'h1000_0080, 0, 8'd0, "R1");
    chkCnt(8'd16, "R1 count");

    // R3: translation with offset, region boundary
    step(1, 8'd17, 32'h2000_0185, 0, 8'd0, "R3");
    step(0, 8'd0, 32'd0, 1, 8'd17, "R3 misaligned");
    step(1, 8'd17, 32'h1000_03C0, 0, 8'd0, "R3");
    step(0, 8'd0, 32'd0, 1, 8'd17, "R3 last slot");
    // R4: addresses in no region
    step(1, 8'd17, 32'h1000_0400, 0, 8'd0, "R4");
    step(1, 8'd17, 32'h0FFF_FFC0, 0, 8'd0, "R4");
    chkCnt(8'd17, "R4 count");
    step(0, 8'd0, 32'd0, 1, 8'd17, "R4 pop");

    // R2: FIFO order
    for (int k = 0; k < 3; k++) step(0, 8'd0, 32'd0, 1, 8'd16, "R2 order");
    chkCnt(8'd16, "R2 count");

    // R6: out-of-range queues
    step(1, 8'd5, 32'h1000_0100, 0, 8'd0, "R6");
    chkCnt(8'd5, "R6 count");
    step(0, 8'd0, 32'd0, 1, 8'd30, "R6 pop");
    chkCnt(8'd16, "R6 no side effect");

    // R8: simultaneous push and pop on the same queue
    step(1, 8'd18, 32'h1000_0140, 1, 8'd18, "R8 empty");
    chkCnt(8'd18, "R8 count");
    step(1, 8'd18, 32'h1000_0180, 1, 8'd18, "R8 single");
    chkCnt(8'd18, "R8 count");
    step(1, 8'd18, 32'h1000_01C0, 0, 8'd0, "R8");
    step(1, 8'd18, 32'h1000_0200, 1, 8'd18, "R8 longer");
    chkCnt(8'd18, "R8 count");
    step(0, 8'd0, 32'd0, 1, 8'd18, "R8 drain");
    step(0, 8'd0, 32'd0, 1, 8'd18, "R8 drain");

    // R9: interleaved queues
    for (int k = 0; k < 8; k++)
      step(1, (k % 2 == 0) ? 8'd19 : 8'd20, idxToAddr(20 + k), 0, 8'd0, "R9");
    chkCnt(8'd19, "R9 count");
    for (int k = 0; k < 4; k++) step(0, 8'd0, 32'd0, 1, 8'd20, "R9 q20");
    for (int k = 0; k < 4; k++) step(0, 8'd0, 32'd0, 1, 8'd19, "R9 q19");

    // random mix (R2, R7, R8)
    for (int it = 0; it < 1500; it++) begin
      bit          pv, ov;
      logic [7:0]  pq, oq;
      logic [31:0] pa;
      int          start, pick, sel;
      pv = 1'($urandom % 2);
      ov = 1'($urandom % 2);
      pq = 8'(14 + $urandom % 12);
      oq = ($urandom % 4 == 0) ? pq : 8'(14 + $urandom % 12);
      pa = '0;
      if ($urandom % 16 == 0) pa = 32'h3000_0000 + ($urandom % 256);
      else begin
        start = int'($urandom % 32);
        pick = -1;
        for (int j = 0; j < 32; j++) begin
          sel = (start + j) % 32;
          if (pick < 0 && !used[sel]) pick = sel;
        end
        if (pick < 0) pv = 1'b0;
        else pa = idxToAddr(pick) + ($urandom % ((pick < 16) ? 64 : 128));
      end
      step(pv, pq, pa, ov, oq, (ov && pv && oq == pq) ? "R8 random" : "R2 random");
      chkCnt(8'(15 + $urandom % 10), "R7 random");
    end

    summary();
  end

endmodule